// File: doc/BRIEF.md
# Lockable Windowed Watchdog Subcounter

This block is a 16-bit watchdog counter that advances on a low-frequency tick qualifier. Software programs a lower (window-open) limit, an upper (timeout) limit and a warning limit. When the count reaches the warning limit, a sticky interrupt can be raised. When the count sits on the upper limit at an advancing tick, a one-cycle fault pulse is issued. A service write restarts the count. A service that comes earlier than the lower limit is treated as a fault too. With auto-service set, the counter restarts itself at the upper limit and raises no fault, so it can serve as a periodic interrupt source.

A key register guards all configuration. The control, limit, config, service and count registers accept writes only after the key value 1 and then the key value 2 have been written. The key value 3 closes them again. The register bus is a plain single-cycle write port with a combinational read port. No data stream passes through the block, so it has no valid/ready handshake and there is no back-pressure. Every write completes in the cycle it is presented.

Top module: `wsc_top`

## Requirements
- R1: After reset the key state reads 0 (locked), the count is 0, and both irq_o and fault_o are low. The upper limit resets to 0xFFFF, and the other limits, the control register and the config register reset to 0.
- R2: The irq status bit is set on an advancing tick that makes the count equal to the warning limit, if config bit 8 is 1. It then stays set until a write to the status register (address 8) with bit 0 = 1. It is not set when config bit 8 is 0.
- R3: With config bit 12 = 0, an advancing tick while the count equals the upper limit sets the count to 0. fault_o is high for exactly the following cycle.
- R4: With config bit 12 = 1, the same event sets the count to 0 and leaves fault_o low.
- R5: On the key register (address 0), a write of 1 from the locked state moves it to state 1. A following write of 2 moves it to state 2 (open). Reading the key register returns the state code.
- R6: While the key state is not open, writes to protected addresses 1 to 7 have no effect. The affected registers are the control, lower, upper, warning, config, service and count registers.
- R7: In state 1, any key write other than 2 returns the state to 0. In the open state, a key write of 3 returns it to 0.
- R8: The count advances by one only on cycles where tick_en is high and control bit 0 (address 1) is 1.
- R9: When unlocked, a write of any value to the service register (address 6) clears the count to 0 in that cycle.
- R10: A service write while the count is below the lower limit (address 2) raises fault_o for one cycle.
- R11: When unlocked, a write to the count register (address 7) loads the count. Addresses 3 and 4 hold the upper and warning limits, address 5 holds the config register, and the count reads back at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count qualifier from the low-frequency tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Sticky warning interrupt |
| fault_o | output | 1 | One-cycle fault pulse |
| count_o | output | 16 | Current count |

## Verification
Every register write, key transition, count step, interrupt set and fault pulse is registered. Each of these results is visible one clock edge after the stimulus is presented, and read data follows the registers with no extra delay. The bench drives inputs on the falling edge and holds them across exactly one rising edge. It then samples outputs at the next falling edge, which is the first point where the result is due. Fault pulses are also counted on every falling edge so that a pulse lasting one cycle is not missed when a check asserts that there were none.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_e;

  localparam int unsigned ADDR_KEY    = 0;
  localparam int unsigned ADDR_CTRL   = 1;
  localparam int unsigned ADDR_LOWER  = 2;
  localparam int unsigned ADDR_UPPER  = 3;
  localparam int unsigned ADDR_WARN   = 4;
  localparam int unsigned ADDR_CFG    = 5;
  localparam int unsigned ADDR_SVC    = 6;
  localparam int unsigned ADDR_COUNT  = 7;
  localparam int unsigned ADDR_STATUS = 8;

  localparam int unsigned CFG_WARN_BIT = 8;
  localparam int unsigned CFG_AUTO_BIT = 12;

  localparam int unsigned KEY_FIRST = 1;
  localparam int unsigned KEY_SECOND = 2;
  localparam int unsigned KEY_CLOSE = 3;
endpackage

// File: rtl/wsc_lock_fsm.sv
module wsc_lock_fsm
  import wsc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  output lock_e         state_o,
  output logic          unlocked_o
);
  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      unique case (state_q)
        LK_CLOSED: state_d = (key_data == DW'(KEY_FIRST)) ? LK_HALF : LK_CLOSED;
        LK_HALF:   state_d = (key_data == DW'(KEY_SECOND)) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   state_d = (key_data == DW'(KEY_CLOSE)) ? LK_CLOSED : LK_OPEN;
        default:   state_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign unlocked_o = (state_q == LK_OPEN);

  AST_OPEN_VIA_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |-> $past(state_q) == LK_HALF); // R5
  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HALF && key_we && key_data != DW'(KEY_SECOND)) |=> state_q == LK_CLOSED); // R7
endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
  import wsc_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          unlocked,
  output logic          key_we,
  output logic          run_en,
  output logic [CW-1:0] lower_lim,
  output logic [CW-1:0] upper_lim,
  output logic [CW-1:0] warn_lim,
  output logic          warn_act,
  output logic          auto_svc,
  output logic          svc_we,
  output logic          cnt_we,
  output logic [CW-1:0] cnt_wdata,
  output logic          irq_clr
);
  logic          prot_ok;
  logic          run_q, warn_act_q, auto_q;
  logic [CW-1:0] lower_q, upper_q, warn_q;

  assign prot_ok  = wr_en && unlocked;
  assign key_we   = wr_en && (wr_addr == AW'(ADDR_KEY));
  assign irq_clr  = wr_en && (wr_addr == AW'(ADDR_STATUS)) && wr_data[0];
  assign svc_we   = prot_ok && (wr_addr == AW'(ADDR_SVC));
  assign cnt_we   = prot_ok && (wr_addr == AW'(ADDR_COUNT));
  assign cnt_wdata = wr_data[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      lower_q    <= '0;
      upper_q    <= '1;
      warn_q     <= '0;
      warn_act_q <= 1'b0;
      auto_q     <= 1'b0;
    end else if (prot_ok) begin
      if (wr_addr == AW'(ADDR_CTRL))  run_q   <= wr_data[0];
      if (wr_addr == AW'(ADDR_LOWER)) lower_q <= wr_data[CW-1:0];
      if (wr_addr == AW'(ADDR_UPPER)) upper_q <= wr_data[CW-1:0];
      if (wr_addr == AW'(ADDR_WARN))  warn_q  <= wr_data[CW-1:0];
      if (wr_addr == AW'(ADDR_CFG)) begin
        warn_act_q <= wr_data[CFG_WARN_BIT];
        auto_q     <= wr_data[CFG_AUTO_BIT];
      end
    end
  end

  assign run_en    = run_q;
  assign lower_lim = lower_q;
  assign upper_lim = upper_q;
  assign warn_lim  = warn_q;
  assign warn_act  = warn_act_q;
  assign auto_svc  = auto_q;

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(upper_q) && $stable(lower_q) && $stable(warn_q)
                   && $stable(run_q) && $stable(auto_q) && $stable(warn_act_q))); // R6
endmodule

// File: rtl/wsc_counter.sv
module wsc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run_en,
  input  logic [CW-1:0] lower_lim,
  input  logic [CW-1:0] upper_lim,
  input  logic [CW-1:0] warn_lim,
  input  logic          warn_act,
  input  logic          auto_svc,
  input  logic          svc_we,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          irq_clr,
  output logic [CW-1:0] count_o,
  output logic          irq_o,
  output logic          fault_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d, fault_q, fault_d, irq_set, adv;

  assign adv = tick_en && run_en;

  always_comb begin
    cnt_d   = cnt_q;
    fault_d = 1'b0;
    irq_set = 1'b0;
    if (svc_we) begin
      cnt_d   = '0;
      fault_d = (cnt_q < lower_lim);
    end else if (cnt_we) begin
      cnt_d = cnt_wdata;
    end else if (adv) begin
      if (cnt_q == upper_lim) begin
        cnt_d   = '0;
        fault_d = !auto_svc;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      irq_set = warn_act && (cnt_d == warn_lim);
    end
    irq_d = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      fault_q <= fault_d;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign fault_o = fault_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q); // R2
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> ($past(svc_we) || $past(adv && !auto_svc))); // R3
  AST_AUTO_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && auto_svc && !svc_we && !cnt_we) |=> !fault_q); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !svc_we && !cnt_we) |=> $stable(cnt_q)); // R8
  AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    svc_we |=> cnt_q == '0); // R9
endmodule

// File: rtl/wsc_top.sv
module wsc_top
  import wsc_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_o,
  output logic          fault_o,
  output logic [CW-1:0] count_o
);
  lock_e         lk_state;
  logic          unlocked, key_we, run_en, warn_act, auto_svc;
  logic          svc_we, cnt_we, irq_clr;
  logic [CW-1:0] lower_lim, upper_lim, warn_lim, cnt_wdata;

  wsc_lock_fsm #(.DW(DW)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(wr_data),
    .state_o(lk_state), .unlocked_o(unlocked)
  );

  wsc_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked), .key_we(key_we), .run_en(run_en),
    .lower_lim(lower_lim), .upper_lim(upper_lim), .warn_lim(warn_lim),
    .warn_act(warn_act), .auto_svc(auto_svc), .svc_we(svc_we), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .irq_clr(irq_clr)
  );

  wsc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .lower_lim(lower_lim), .upper_lim(upper_lim), .warn_lim(warn_lim),
    .warn_act(warn_act), .auto_svc(auto_svc), .svc_we(svc_we), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .irq_clr(irq_clr),
    .count_o(count_o), .irq_o(irq_o), .fault_o(fault_o)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      AW'(ADDR_KEY):    rd_data = DW'(lk_state);
      AW'(ADDR_CTRL):   rd_data = DW'(run_en);
      AW'(ADDR_LOWER):  rd_data = DW'(lower_lim);
      AW'(ADDR_UPPER):  rd_data = DW'(upper_lim);
      AW'(ADDR_WARN):   rd_data = DW'(warn_lim);
      AW'(ADDR_CFG): begin
        rd_data[CFG_WARN_BIT] = warn_act;
        rd_data[CFG_AUTO_BIT] = auto_svc;
      end
      AW'(ADDR_COUNT):  rd_data = DW'(count_o);
      AW'(ADDR_STATUS): rd_data = DW'(irq_o);
      default:          rd_data = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!fault_o && !irq_o)); // R1
endmodule

// File: tb/wsc_top_test.sv
`timescale 1ns/1ps
module wsc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o, fault_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  int fault_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wsc_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .fault_o(fault_o), .count_o(count_o)
  );

  always @(negedge clk) if (rst_n && fault_o) fault_seen++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 32'(data);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(posedge clk); @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(int addr, output logic [31:0] v);
    rd_addr = 4'(addr); #1; v = rd_data;
  endtask

  task automatic unlock();
    wr(0, 1); wr(0, 2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); check("R1 key state", v, 0);
    check("R1 count", 32'(count_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 fault", 32'(fault_o), 0);
    rd(3, v); check("R1 upper reset", v, 32'hFFFF);
  endtask

  task automatic t_locked_ignored();
    logic [31:0] v;
    wr(3, 5); rd(3, v); check("R6 upper held", v, 32'hFFFF);
    wr(1, 1); ticks(2); check("R6 ctrl held, no count", 32'(count_o), 0);
    wr(7, 9); check("R6 count write ignored", 32'(count_o), 0);
  endtask

  task automatic t_key_seq();
    logic [31:0] v;
    wr(0, 1); rd(0, v); check("R5 half state", v, 1);
    wr(0, 2); rd(0, v); check("R5 open state", v, 2);
    wr(0, 3); rd(0, v); check("R7 close key", v, 0);
    wr(0, 1); wr(0, 5); rd(0, v); check("R7 bad second key", v, 0);
    wr(0, 2); rd(0, v); check("R7 second key alone", v, 0);
  endtask

  task automatic t_enable();
    unlock();
    wr(3, 100);
    wr(1, 0); ticks(3); check("R8 disabled ctrl", 32'(count_o), 0);
    wr(1, 1); repeat (3) @(negedge clk); check("R8 no tick", 32'(count_o), 0);
    ticks(5); check("R8 five ticks", 32'(count_o), 5);
    wr(6, 32'h1234); check("R9 service clears", 32'(count_o), 0);
    wr(7, 50); check("R11 count load", 32'(count_o), 50);
  endtask

  task automatic t_warn();
    wr(4, 3); wr(5, 32'h100); wr(6, 0);
    ticks(2); check("R2 before warn", 32'(irq_o), 0);
    ticks(1); check("R2 at warn", 32'(irq_o), 1);
    ticks(2); check("R2 sticky", 32'(irq_o), 1);
    wr(8, 1); check("R2 cleared", 32'(irq_o), 0);
    wr(5, 0); wr(6, 0); ticks(3); check("R2 action off", 32'(irq_o), 0);
  endtask

  task automatic t_timeout();
    wr(3, 4); wr(6, 0); fault_seen = 0;
    ticks(4); check("R3 at upper", 32'(count_o), 4);
    check("R3 no early fault", 32'(fault_seen), 0);
    ticks(1); check("R3 fault pulse", 32'(fault_o), 1);
    check("R3 wrap", 32'(count_o), 0);
    @(negedge clk); check("R3 pulse one cycle", 32'(fault_o), 0);
  endtask

  task automatic t_auto();
    wr(5, 32'h1000); wr(6, 0); fault_seen = 0;
    ticks(5); check("R4 auto wrap", 32'(count_o), 0);
    check("R4 no fault", 32'(fault_seen), 0);
    ticks(2); check("R4 continues", 32'(count_o), 2);
    wr(5, 0);
  endtask

  task automatic t_window();
    wr(3, 100); wr(2, 3); wr(6, 0); fault_seen = 0;
    ticks(1); wr(6, 0); check("R10 early fault", 32'(fault_seen), 1);
    check("R10 count cleared", 32'(count_o), 0);
    ticks(3); fault_seen = 0; wr(6, 0);
    check("R10 in window", 32'(fault_seen), 0);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(0, 3); wr(3, 7); rd(3, v); check("R6 after relock", v, 100);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_ignored();
    t_key_seq();
    t_enable();
    t_warn();
    t_timeout();
    t_auto();
    t_window();
    t_relock();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule